// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This peripheral holds a 16-bit up-counter on an 8-bit register bus. The count source is either an internal tick, derived from the system clock divided by four, or the rising edges of an external clock pin. A power-of-two prescaler (1, 2, 4 or 8) sits between the source and the counter. A run bit gates counting. Edges from the external pin can pass through a two-stage synchronizer, or take a shorter path that skips it.

When the counter wraps from 0xFFFF to 0x0000, it sets a sticky interrupt flag. A compare unit elsewhere in the chip can pulse a trigger input that zeroes the count. An optional wide access mode routes the upper byte through a holding register. In that mode, software can read and write all 16 bits as one consistent value over the narrow bus.

Register map (byte addresses): 0 = count low byte, 1 = count high byte, 2 = control, 3 = flag (bit 0). Control bits: bit 0 run, bit 1 source select (1 = external pin), bit 2 skip-synchronizer, bits 4:3 prescale code n (divide by 2^n), bit 5 trigger enable, bit 6 reserved (reads 0), bit 7 wide access mode.

Top module: `cnt16_timer`

## Requirements
- R1: After reset the count, the control register and the flag all read 0, and irq_o is low.
- R2: With run=1, source=internal and prescale code 0, the count advances by one every 4 clock cycles. The first step lands 4 cycles after the control write.
- R3: Prescale code n divides the selected source by 2^n (code 2 with the internal source gives one step per 16 cycles).
- R4: While run=0, the count holds its value.
- R5: With source=external and the synchronizer in use, each rising edge of ext_clk_i advances the count by exactly one at prescale code 0. Falling edges do nothing.
- R6: With the synchronizer in use, the count changes on the second clock edge after the one that first samples ext_clk_i high. With skip-synchronizer set, it changes on the first edge after that one.
- R7: A step from 0xFFFF sets the flag and irq_o. The flag stays set until a bus write of 0 to bit 0 of address 3. A write of 1 leaves it unchanged.
- R8: If a wrap and a flag-clearing write happen in the same cycle, the flag ends set.
- R9: With trigger enable set, evt_clr_i high zeroes the count, and this overrides a step in the same cycle. With trigger enable clear, evt_clr_i is ignored.
- R10: In wide mode, a read of address 0 copies the live high byte into a holding register, and address 1 returns the holding register rather than the live byte.
- R11: In wide mode, a write to address 1 fills only the holding register. A following write to address 0 loads the holding byte and the written low byte into the count together.
- R12: Outside wide mode, writes to address 0 and address 1 change the matching count byte directly, and address 1 reads the live high byte.
- R13: A write to either count byte or to the control register restarts the prescaler at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe (side effect only in wide mode) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| ext_clk_i | input | 1 | External count clock |
| evt_clr_i | input | 1 | Compare-event trigger that clears the count |
| irq_o | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach from the ports is a counter wrap in exactly the cycle that a flag-clearing write lands. The bench preloads 0xFFFF and raises the external pin in synchronized mode. It then counts the two clock edges through the synchronizer and issues the write so that the write commits on the very edge where the step occurs. The same edge counting separates the synchronized and skip-synchronizer paths by one cycle. A prescaler restart is shown by a single external edge that fails to step the count after an intervening byte write.

// File: rtl/cnt16_pkg.sv
package cnt16_pkg;
  localparam int CNT_W = 16;
  localparam int BUS_W = 8;
  localparam int DIV_W = 2;

  typedef enum logic [1:0] {
    ADR_LO  = 2'd0,
    ADR_HI  = 2'd1,
    ADR_CTL = 2'd2,
    ADR_FLG = 2'd3
  } adr_e;

  typedef struct packed {
    logic             wide;
    logic             rsvd;
    logic             evt_en;
    logic [DIV_W-1:0] div;
    logic             no_sync;
    logic             ext;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/cnt16_src.sv
// Count source: internal divide-by-four tick or rising edges of the external pin
module cnt16_src #(
  parameter int SYNC_STAGES = 2,
  parameter int PHASE_W     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_sel,
  input  logic no_sync,
  input  logic ext_clk,
  output logic tick
);
  logic [SYNC_STAGES:0] chain_q, chain_d;
  logic [PHASE_W-1:0]   phase_q, phase_d;
  logic                 edge_sync, edge_fast, int_tick;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-1:0], ext_clk};
    phase_d = (run && !ext_sel) ? phase_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      phase_q <= '0;
    end else begin
      chain_q <= chain_d;
      phase_q <= phase_d;
    end
  end

  assign edge_fast = chain_q[0] & ~chain_q[1];
  assign edge_sync = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign int_tick  = (phase_q == {PHASE_W{1'b1}});
  assign tick      = run & (ext_sel ? (no_sync ? edge_fast : edge_sync) : int_tick);
endmodule

// File: rtl/cnt16_prescale.sv
// Power-of-two prescaler: one step out per 2^div ticks in
module cnt16_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  input  logic             clr,
  output logic             step
);
  localparam int PW = (1 << DIV_W) - 1;

  logic [PW-1:0] pre_q, pre_d, lim;

  always_comb begin
    lim   = PW'((32'd1 << div) - 32'd1);
    step  = tick && (pre_q == lim);
    pre_d = pre_q;
    if (clr)       pre_d = '0;
    else if (step) pre_d = '0;
    else if (tick) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/cnt16_count.sv
// Counter, high-byte holding register and sticky wrap flag
module cnt16_count #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             evt_hit,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             rd_lo,
  input  logic             wide,
  input  logic [BUS_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic [BUS_W-1:0] hold_o,
  output logic             flag_o
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HI_W-1:0]  hold_q, hold_d;
  logic             flag_q, flag_d;
  logic             load, wrap;

  always_comb begin
    load = wr_lo || (wr_hi && !wide);
    wrap = step && !evt_hit && !load && (cnt_q == {CNT_W{1'b1}});

    cnt_d = cnt_q;
    if (evt_hit)          cnt_d = '0;
    else if (wr_lo)       cnt_d = {(wide ? hold_q : cnt_q[CNT_W-1:BUS_W]), wdata};
    else if (wr_hi && !wide) cnt_d[CNT_W-1:BUS_W] = wdata;
    else if (step)        cnt_d = cnt_q + 1'b1;

    hold_d = hold_q;
    if (wide && wr_hi)      hold_d = wdata;
    else if (wide && rd_lo) hold_d = cnt_q[CNT_W-1:BUS_W];

    flag_d = flag_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cnt16_timer.sv
module cnt16_timer
  import cnt16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             ext_clk_i,
  input  logic             evt_clr_i,
  output logic             irq_o
);
  logic [1:0]       rst_pipe;
  logic             rst_n_sync;
  ctrl_t            ctrl_q, ctrl_d;
  logic             wr_lo, wr_hi, wr_ctl, wr_flg, rd_lo;
  logic             tick, step, evt_hit, flag;
  logic [CNT_W-1:0] cnt;
  logic [BUS_W-1:0] hold;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  always_comb begin
    wr_lo   = wr_en_i && (addr_i == ADR_LO);
    wr_hi   = wr_en_i && (addr_i == ADR_HI);
    wr_ctl  = wr_en_i && (addr_i == ADR_CTL);
    wr_flg  = wr_en_i && (addr_i == ADR_FLG);
    rd_lo   = rd_en_i && (addr_i == ADR_LO);
    evt_hit = evt_clr_i && ctrl_q.evt_en;
    ctrl_d  = ctrl_q;
    if (wr_ctl) begin
      ctrl_d      = ctrl_t'(wdata_i);
      ctrl_d.rsvd = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) ctrl_q <= '0;
    else             ctrl_q <= ctrl_d;
  end

  cnt16_src #(.SYNC_STAGES(2), .PHASE_W(2)) u_src (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .run     (ctrl_q.run),
    .ext_sel (ctrl_q.ext),
    .no_sync (ctrl_q.no_sync),
    .ext_clk (ext_clk_i),
    .tick    (tick)
  );

  cnt16_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .tick  (tick),
    .div   (ctrl_q.div),
    .clr   (wr_lo | wr_hi | wr_ctl),
    .step  (step)
  );

  cnt16_count #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .step     (step),
    .evt_hit  (evt_hit),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .rd_lo    (rd_lo),
    .wide     (ctrl_q.wide),
    .wdata    (wdata_i),
    .flag_clr (wr_flg & ~wdata_i[0]),
    .cnt_o    (cnt),
    .hold_o   (hold),
    .flag_o   (flag)
  );

  always_comb begin
    unique case (addr_i)
      ADR_LO:  rdata_o = cnt[BUS_W-1:0];
      ADR_HI:  rdata_o = ctrl_q.wide ? hold : cnt[CNT_W-1:BUS_W];
      ADR_CTL: rdata_o = ctrl_q;
      default: rdata_o = {{(BUS_W-1){1'b0}}, flag};
    endcase
  end

  assign irq_o = flag;
endmodule

// File: rtl/cnt16_timer_chk.sv
module cnt16_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic        wr_en,
  input logic        wdata0,
  input logic        evt,
  input logic        evt_en,
  input logic        run,
  input logic        step,
  input logic [15:0] cnt,
  input logic        flag
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (addr[1] == 1'b0);

  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !(evt && evt_en) && !cnt_wr) |=> (cnt == $past(cnt) + 16'd1));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(evt && evt_en) && !cnt_wr) |=> $stable(cnt));

  // R9
  a_r9_evt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && evt_en) |=> (cnt == 16'd0));

  // R7
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && addr == 2'd3 && !wdata0)) |=> flag);

  // R8
  a_r8_wrap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == 16'hFFFF && !(evt && evt_en) && !cnt_wr) |=> (flag && cnt == 16'd0));
endmodule

bind cnt16_timer cnt16_timer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .addr   (addr_i),
  .wr_en  (wr_en_i),
  .wdata0 (wdata_i[0]),
  .evt    (evt_clr_i),
  .evt_en (ctrl_q.evt_en),
  .run    (ctrl_q.run),
  .step   (step),
  .cnt    (cnt),
  .flag   (flag)
);

// File: tb/cnt16_timer_test.sv
module cnt16_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr_i;
  logic       wr_en_i, rd_en_i, ext_clk_i, evt_clr_i;
  logic [7:0] wdata_i, rdata_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cnt16_timer uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ext_clk_i(ext_clk_i), .evt_clr_i(evt_clr_i), .irq_o(irq_o)
  );

  // monitor: samples shortly before the edge that consumes the read
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rd_en_i && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata_o !== e) begin
          fails++;
          $display("FAIL %s: actual=%02h expected=%02h", t, rdata_o, e);
        end
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    addr_i = a; rd_en_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", t, irq_o, e);
    end
  endtask

  task automatic pulse();
    ext_clk_i = 1'b1;
    repeat (3) @(negedge clk);
    ext_clk_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_cnt();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr_i = '0; wr_en_i = 0; rd_en_i = 0; wdata_i = '0;
    ext_clk_i = 0; evt_clr_i = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(2'd0, 8'h00, "R1 count low");
    rd(2'd1, 8'h00, "R1 count high");
    rd(2'd2, 8'h00, "R1 control");
    rd(2'd3, 8'h00, "R1 flag");
    chk_irq(1'b0, "R1 irq");

    // R2 internal source, divide by 1: step every 4 cycles
    wr(2'd2, 8'h01);
    repeat (40) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd0, 8'd10, "R2 internal rate");

    // R3 prescale code 2: step every 16 cycles
    clear_cnt();
    wr(2'd2, 8'h11);
    repeat (160) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd0, 8'd10, "R3 prescale by 4");

    // R4 stopped counter holds
    repeat (20) @(negedge clk);
    rd(2'd0, 8'd10, "R4 hold while stopped");

    // R5 synchronized external edges
    clear_cnt();
    wr(2'd2, 8'h03);
    for (int i = 0; i < 5; i++) pulse();
    repeat (6) @(negedge clk);
    rd(2'd0, 8'd5, "R5 five edges");

    // R3 external with prescale code 1
    clear_cnt();
    wr(2'd2, 8'h0B);
    for (int i = 0; i < 6; i++) pulse();
    rd(2'd0, 8'd3, "R3 prescale by 2 external");

    // R6 latency: synchronized path
    wr(2'd2, 8'h03);
    clear_cnt();
    ext_clk_i = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(2'd0, 8'd0, "R6 sync not yet");
    rd(2'd0, 8'd1, "R6 sync stepped");
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk);

    // R6 latency: skip-synchronizer path
    wr(2'd2, 8'h07);
    clear_cnt();
    ext_clk_i = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(2'd0, 8'd1, "R6 fast path one cycle earlier");
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk);

    // R12 byte writes, R7 wrap sets flag
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'hFF, "R12 direct high write");
    rd(2'd0, 8'hFF, "R12 direct low write");
    wr(2'd2, 8'h03);
    pulse();
    rd(2'd0, 8'h00, "R7 wrapped low");
    rd(2'd1, 8'h00, "R7 wrapped high");
    chk_irq(1'b1, "R7 irq after wrap");
    wr(2'd3, 8'h01);
    rd(2'd3, 8'h01, "R7 write 1 keeps flag");
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00, "R7 write 0 clears flag");
    chk_irq(1'b0, "R7 irq cleared");

    // R8 wrap and clear in the same cycle
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h03);
    ext_clk_i = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(2'd3, 8'h00);
    chk_irq(1'b1, "R8 wrap beats clear");
    rd(2'd0, 8'h00, "R8 count wrapped");
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd3, 8'h00);

    // R9 trigger ignored when disabled
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    evt_clr_i = 1'b1; @(negedge clk); evt_clr_i = 1'b0;
    rd(2'd0, 8'h34, "R9 trigger ignored low");
    rd(2'd1, 8'h12, "R9 trigger ignored high");
    // R9 trigger clears when enabled
    wr(2'd2, 8'h20);
    evt_clr_i = 1'b1; @(negedge clk); evt_clr_i = 1'b0;
    rd(2'd0, 8'h00, "R9 trigger clears low");
    rd(2'd1, 8'h00, "R9 trigger clears high");
    // R9 trigger beats steps while running
    evt_clr_i = 1'b1;
    wr(2'd2, 8'h21);
    repeat (20) @(negedge clk);
    rd(2'd0, 8'h00, "R9 trigger over step");
    evt_clr_i = 1'b0;
    wr(2'd2, 8'h00);

    // R11 wide write goes through the holding register
    clear_cnt();
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'h00);
    rd(2'd1, 8'h00, "R11 high untouched by wide high write");
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h5A);
    wr(2'd0, 8'hC3);
    wr(2'd2, 8'h00);
    rd(2'd1, 8'h5A, "R11 high loaded with low write");
    rd(2'd0, 8'hC3, "R11 low loaded");

    // R10 wide read latches high byte on low read
    wr(2'd2, 8'h80);
    rd(2'd0, 8'hC3, "R10 low read");
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h77);
    wr(2'd2, 8'h80);
    rd(2'd1, 8'h5A, "R10 high from holding register");
    rd(2'd0, 8'hC3, "R10 low read again");
    rd(2'd1, 8'h77, "R10 holding refreshed");
    wr(2'd2, 8'h00);

    // R13 byte write restarts prescaler
    clear_cnt();
    wr(2'd2, 8'h0B);
    pulse();
    wr(2'd0, 8'h00);
    pulse();
    rd(2'd0, 8'h00, "R13 restart needs two edges");
    pulse();
    rd(2'd0, 8'h01, "R13 second edge steps");

    while (exp_q.size() > 0) @(negedge clk);
    finish_run();
  end
endmodule